// File: doc/BRIEF.md
# Receive Packet Header Validator

This block checks transaction-layer packets arriving on a receive port before they are passed on. Packets come in as a stream of 32-bit words, with a start marker on the first word and an end marker on the last word. The block decodes the format, type, digest and length fields of the first header word. It counts every word of the packet and works out a running end-to-end CRC. One cycle after the end word, it gives a single verdict: good, malformed, or end-to-end CRC error. With the verdict it reports the number of the port that received the packet.

A packet is malformed if its format/type pairing is not legal, or if its word count does not match the count that its header implies. The trailing end-to-end CRC word is checked only when the digest bit is set. A CRC mismatch raises its own flag, separate from the malformed flag. A packet with either flag is meant to be discarded by the logic that follows.

Top module: `rx_hdr_validator`

## Requirements
- R1: After reset, verdictValid, verdictGood, verdictMalformed and verdictEcrcErr are all low, and no verdict appears until an end word has been taken.
- R2: For each accepted end word, verdictValid is high for exactly the following cycle. In that cycle exactly one of verdictGood, verdictMalformed and verdictEcrcErr is high. All three are low whenever verdictValid is low.
- R3: Header word 0 fields: format in bits 30:29, type in bits 28:24, digest in bit 15, length in bits 9:0. Format bit 0 set means a 4-word header, clear means a 3-word header. Format bit 1 set means the packet carries payload.
- R4: Legal pairings are: type 00000 with any format; type 00001 with formats 00 or 01; types 00010, 00100, 00101 and 01010 with formats 00 or 10; types 10xxx with formats 01 or 11. Any other pairing gives verdictMalformed.
- R5: The expected word count is header words plus payload words plus one when the digest bit is set. Payload words equal the length field for data-carrying formats and are zero otherwise. Any difference from the received word count gives verdictMalformed.
- R6: A length field of 0 in a data-carrying format stands for 1024 payload words.
- R7: When the digest bit is set and the packet is not malformed, the last word is compared with the end-to-end CRC of all earlier words. A mismatch gives verdictEcrcErr, not verdictMalformed. The CRC uses polynomial 0x04C11DB7, starts from 0xFFFFFFFF, shifts each word in MSB first, and is complemented at the end.
- R8: When the digest bit is clear, the last word is not treated as a CRC and its value does not affect the verdict.
- R9: errPort shows, with each verdict, the rxPort value that was present on that packet's start word.
- R10: Words with inValid low, and valid words without a start marker that arrive outside a packet, are ignored: they produce no verdict and do not disturb the next packet.
- R11: A start word that arrives inside an open packet drops the open packet without a verdict and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Word on inData is present |
| inSop | input | 1 | First word of a packet |
| inEop | input | 1 | Last word of a packet |
| inData | input | 32 | Packet word |
| rxPort | input | PORT_W | Number of the receiving port, sampled on the start word |
| verdictValid | output | 1 | Verdict strobe, one cycle after the end word |
| verdictGood | output | 1 | Packet passed all checks |
| verdictMalformed | output | 1 | Illegal format/type pairing or length mismatch |
| verdictEcrcErr | output | 1 | End-to-end CRC mismatch |
| errPort | output | PORT_W | Receiving port of the packet the verdict refers to |

## Verification
Header-only reads and completions and 4-word messages show whether the 3- and 4-word header lengths are decoded correctly. Writes with payload, including the zero length that stands for 1024 words, test the length arithmetic. Packets one word short or one word long separate a length mismatch from a good packet, and an illegal format/type pairing with a correct length isolates the legality check. Digest packets with a correct and a corrupted trailing word separate the CRC flag from the malformed flag, and a no-digest packet with an arbitrary last word shows that no CRC is checked. Stray words, idle gaps and a restarted packet check that only framed words count.

// File: rtl/rxhv_pkg.sv
package rxhv_pkg;

  localparam int WORD_W = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
  localparam int MAX_PAY = 1024;

  // strobes from control to datapath
  typedef struct packed {
    logic sop;   // accepted start word
    logic beat;  // accepted word belonging to a packet
    logic eop;   // accepted end word
  } ctlStrobe_t;

  // one 32-bit word shifted into the CRC, MSB first
  function automatic logic [31:0] crcWord(input logic [31:0] crcIn,
                                          input logic [31:0] word);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ word[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic legalCombo(input logic [1:0] fmt,
                                      input logic [4:0] typ);
    logic ok;
    ok = 1'b0;
    casez (typ)
      5'b00000: ok = 1'b1;
      5'b00001: ok = !fmt[1];
      5'b00010,
      5'b00100,
      5'b00101,
      5'b01010: ok = !fmt[0];
      5'b10???: ok = fmt[0];
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/rxhv_ctrl.sv
module rxhv_ctrl
  import rxhv_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  output ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] beatIdx
);

  logic             inPkt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobe.sop  = inValid && inSop;
    strobe.beat = inValid && (inSop || inPkt);
    strobe.eop  = strobe.beat && inEop;
    beatIdx     = strobe.sop ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt <= 1'b0;
      cnt   <= '0;
    end else if (strobe.beat) begin
      inPkt <= !strobe.eop;
      cnt   <= (&beatIdx) ? beatIdx : beatIdx + 1'b1;
    end
  end

  // after an end word, a word without start marker is not taken
  AST_NO_BEAT_AFTER_EOP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eop |=> (!strobe.beat || strobe.sop)); // R10

  // word index climbs by one per taken word inside a packet
  AST_IDX_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.beat && !strobe.eop && !(&beatIdx)) |=>
      (!strobe.beat || strobe.sop || beatIdx == $past(beatIdx) + 1'b1)); // R5

  // a start word always opens at index zero
  AST_SOP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sop |-> (beatIdx == '0 && strobe.beat)); // R11

endmodule

// File: rtl/rxhv_datapath.sv
module rxhv_datapath
  import rxhv_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [CNT_W-1:0]  beatIdx,
  input  logic [WORD_W-1:0] inData,
  input  logic [PORT_W-1:0] rxPort,
  output logic              verdictValid,
  output logic              verdictGood,
  output logic              verdictMalformed,
  output logic              verdictEcrcErr,
  output logic [PORT_W-1:0] errPort
);

  localparam int TOT_W = CNT_W + 1;

  logic [WORD_W-1:0] hdrWord;
  logic [PORT_W-1:0] portReg;
  logic [31:0]       crcReg;

  logic [WORD_W-1:0] curHdr;
  logic [PORT_W-1:0] curPort;
  logic [1:0]        curFmt;
  logic [4:0]        curType;
  logic              curTd;
  logic [9:0]        curLen;
  logic [2:0]        hdrDw;
  logic [10:0]       payDw;
  logic [TOT_W-1:0]  expTotal;
  logic [TOT_W-1:0]  gotTotal;
  logic [31:0]       crcIn;
  logic [31:0]       crcNext;
  logic              isMalformed;
  logic              isEcrcBad;

  always_comb begin
    curHdr   = (beatIdx == '0) ? inData : hdrWord;
    curPort  = strobe.sop ? rxPort : portReg;
    curFmt   = curHdr[30:29];
    curType  = curHdr[28:24];
    curTd    = curHdr[15];
    curLen   = curHdr[9:0];
    hdrDw    = curFmt[0] ? 3'd4 : 3'd3;
    if (!curFmt[1])          payDw = 11'd0;
    else if (curLen == '0)   payDw = 11'(MAX_PAY);
    else                     payDw = {1'b0, curLen};
    expTotal = TOT_W'(hdrDw) + TOT_W'(payDw) + TOT_W'(curTd);
    gotTotal = {1'b0, beatIdx} + 1'b1;
    crcIn    = (beatIdx == '0) ? CRC_SEED : crcReg;
    crcNext  = crcWord(crcIn, inData);
    isMalformed = !legalCombo(curFmt, curType) || (gotTotal != expTotal);
    isEcrcBad   = curTd && !isMalformed && (inData != ~crcIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrWord <= '0;
      portReg <= '0;
      crcReg  <= CRC_SEED;
    end else if (strobe.beat) begin
      if (beatIdx == '0) hdrWord <= inData;
      if (strobe.sop)    portReg <= rxPort;
      crcReg <= crcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictValid     <= 1'b0;
      verdictGood      <= 1'b0;
      verdictMalformed <= 1'b0;
      verdictEcrcErr   <= 1'b0;
      errPort          <= '0;
    end else begin
      verdictValid     <= strobe.eop;
      verdictGood      <= strobe.eop && !isMalformed && !isEcrcBad;
      verdictMalformed <= strobe.eop && isMalformed;
      verdictEcrcErr   <= strobe.eop && isEcrcBad;
      if (strobe.eop) errPort <= curPort;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $countones({verdictGood, verdictMalformed, verdictEcrcErr}) == 1); // R2

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |-> !(verdictGood || verdictMalformed || verdictEcrcErr)); // R2

  AST_ECRC_NEEDS_DIGEST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eop && !curTd) |=> !verdictEcrcErr); // R8

  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.eop) |-> $stable(errPort)); // R9

endmodule

// File: rtl/rx_hdr_validator.sv
module rx_hdr_validator
  import rxhv_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [31:0]       inData,
  input  logic [PORT_W-1:0] rxPort,
  output logic              verdictValid,
  output logic              verdictGood,
  output logic              verdictMalformed,
  output logic              verdictEcrcErr,
  output logic [PORT_W-1:0] errPort
);

  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] beatIdx;

  rxhv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSop   (inSop),
    .inEop   (inEop),
    .strobe  (strobe),
    .beatIdx (beatIdx)
  );

  rxhv_datapath #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .beatIdx          (beatIdx),
    .inData           (inData),
    .rxPort           (rxPort),
    .verdictValid     (verdictValid),
    .verdictGood      (verdictGood),
    .verdictMalformed (verdictMalformed),
    .verdictEcrcErr   (verdictEcrcErr),
    .errPort          (errPort)
  );

endmodule

// File: tb/rx_hdr_validator_tb.sv
module rx_hdr_validator_tb;

  localparam int PORT_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inSop = 1'b0;
  logic              inEop = 1'b0;
  logic [31:0]       inData = '0;
  logic [PORT_W-1:0] rxPort = '0;
  logic              verdictValid, verdictGood, verdictMalformed, verdictEcrcErr;
  logic [PORT_W-1:0] errPort;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] pkt [0:1100];
  int pktLen;

  always #4 clk = ~clk;  // 125 MHz

  rx_hdr_validator #(.PORT_W(PORT_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inData(inData), .rxPort(rxPort), .verdictValid(verdictValid),
    .verdictGood(verdictGood), .verdictMalformed(verdictMalformed),
    .verdictEcrcErr(verdictEcrcErr), .errPort(errPort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference CRC: bit at a time, computed from the stated rule
  function automatic logic [31:0] refCrc(input int n);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int w = 0; w < n; w++) begin
      for (int b = 31; b >= 0; b--) begin
        if (r[31] != pkt[w][b]) r = (r << 1) ^ 32'h04C11DB7;
        else                   r = r << 1;
      end
    end
    return ~r;
  endfunction

  // build header + nPay payload words (+ CRC word when td)
  task automatic build(input logic [1:0] fmt, input logic [4:0] typ, input bit td,
                       input logic [9:0] len, input int nPay, input bit badCrc);
    int h = fmt[0] ? 4 : 3;
    pkt[0] = {1'b0, fmt, typ, 8'h00, td, 5'h00, len};
    for (int i = 1; i < h; i++) pkt[i] = 32'hA5A50000 + i;
    for (int i = 0; i < nPay; i++) pkt[h+i] = 32'h12340000 ^ (i * 32'h9E37);
    pktLen = h + nPay;
    if (td) begin
      pkt[pktLen] = refCrc(pktLen) ^ (badCrc ? 32'h1 : 32'h0);
      pktLen++;
    end
  endtask

  // kind: 0 good, 1 malformed, 2 ecrc error
  task automatic sendPkt(input string req, input logic [PORT_W-1:0] port, input int kind);
    for (int i = 0; i < pktLen; i++) begin
      @(negedge clk);
      if (i == pktLen - 1) chk({req, " no early verdict"}, verdictValid, 0);
      inValid = 1'b1;
      inSop   = (i == 0);
      inEop   = (i == pktLen - 1);
      inData  = pkt[i];
      rxPort  = (i == 0) ? port : ~port;
    end
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    chk({req, " valid"}, verdictValid, 1);
    chk({req, " good"}, verdictGood, kind == 0);
    chk({req, " malformed"}, verdictMalformed, kind == 1);
    chk({req, " ecrc"}, verdictEcrcErr, kind == 2);
    chk({req, " port R9"}, errPort, port);
    @(negedge clk);
    chk({req, " single-cycle R2"}, verdictValid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid", verdictValid, 0);
    chk("R1 flags", {verdictGood, verdictMalformed, verdictEcrcErr}, 0);
  endtask

  task automatic t_headerOnly;
    build(2'b00, 5'b00000, 0, 10'd1, 0, 0); sendPkt("R3 3dw read", 3'd1, 0);
    build(2'b01, 5'b00000, 0, 10'd4, 0, 0); sendPkt("R3 4dw read", 3'd2, 0);
    build(2'b00, 5'b01010, 0, 10'd0, 0, 0); sendPkt("R4 completion", 3'd3, 0);
    build(2'b01, 5'b10100, 0, 10'd0, 0, 0); sendPkt("R4 message", 3'd4, 0);
  endtask

  task automatic t_payload;
    build(2'b10, 5'b00000, 0, 10'd5, 5, 0);   sendPkt("R5 write 5", 3'd5, 0);
    build(2'b11, 5'b10001, 0, 10'd2, 2, 0);   sendPkt("R5 msg data", 3'd6, 0);
    build(2'b10, 5'b00000, 0, 10'd0, 1024, 0); sendPkt("R6 len0=1024", 3'd7, 0);
  endtask

  task automatic t_illegal;
    build(2'b01, 5'b00010, 0, 10'd1, 0, 0); sendPkt("R4 io 4dw", 3'd1, 1);
    build(2'b00, 5'b10000, 0, 10'd1, 0, 0); sendPkt("R4 msg 3dw", 3'd2, 1);
    build(2'b00, 5'b01111, 0, 10'd1, 0, 0); sendPkt("R4 bad type", 3'd3, 1);
  endtask

  task automatic t_length;
    build(2'b10, 5'b00000, 0, 10'd5, 4, 0);   sendPkt("R5 short", 3'd4, 1);
    build(2'b10, 5'b00000, 0, 10'd5, 6, 0);   sendPkt("R5 long", 3'd5, 1);
    build(2'b00, 5'b00000, 0, 10'd3, 1, 0);   sendPkt("R5 nodata extra", 3'd6, 1);
    build(2'b10, 5'b00000, 0, 10'd0, 1023, 0); sendPkt("R6 len0 short", 3'd7, 1);
  endtask

  task automatic t_ecrc;
    build(2'b10, 5'b00000, 1, 10'd3, 3, 0); sendPkt("R7 crc ok", 3'd2, 0);
    build(2'b10, 5'b00000, 1, 10'd3, 3, 1); sendPkt("R7 crc bad", 3'd3, 2);
    build(2'b01, 5'b00000, 1, 10'd0, 0, 1); sendPkt("R7 hdr crc bad", 3'd4, 2);
    build(2'b10, 5'b00000, 1, 10'd3, 2, 1); sendPkt("R7 malformed wins", 3'd5, 1);
  endtask

  task automatic t_noDigest;
    build(2'b10, 5'b00000, 0, 10'd2, 2, 0);
    pkt[pktLen-1] = 32'hDEADBEEF;
    sendPkt("R8 last word free", 3'd6, 0);
  endtask

  task automatic t_ignored;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSop = 1'b0; inEop = (i == 3); inData = 32'h4000_0000;
    end
    @(negedge clk);
    inValid = 1'b0; inEop = 1'b1; inSop = 1'b1;
    @(negedge clk);
    inEop = 1'b0; inSop = 1'b0;
    chk("R10 stray words", verdictValid, 0);
    @(negedge clk);
    chk("R10 idle eop", verdictValid, 0);
    build(2'b10, 5'b00000, 0, 10'd1, 1, 0); sendPkt("R10 next ok", 3'd1, 0);
  endtask

  task automatic t_restart;
    @(negedge clk);
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b0; inData = 32'h4000_0003;
    @(negedge clk);
    inSop = 1'b0; inData = 32'h0;
    build(2'b00, 5'b00100, 0, 10'd1, 0, 0); sendPkt("R11 restart", 3'd2, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    t_reset;
    t_headerOnly;
    t_payload;
    t_illegal;
    t_length;
    t_ecrc;
    t_noDigest;
    t_ignored;
    t_restart;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule